// File: doc/BRIEF.md
# HDLC Receive Buffer with Sticky Status

This block is the receive-side store of an HDLC controller. It sits between a bit-level deframer and a host register interface. The deframer delivers received bytes one per cycle. Each byte carries a last-byte tag and a two-bit packet outcome code. The deframer also sends one-cycle pulses for a flag, an abort, a go-ahead pattern, each received bit and a captured CRC field. The bytes go into a first-in first-out store. The host sees the head entry without having to pop it first, and it pops the entry to move on.

A set of sticky interrupt bits records events between host reads. A status read clears every bit, but an event that lands in the same cycle as the read still sets its bit. If the store overflows, the receiver stops accepting bytes until the deframer sees the next flag. An abort counts only after enough bits of the packet have arrived. One status position reports either a received frame abort or a transmit underrun, chosen by a select input. The received CRC field is held in two byte registers, exactly as it was sent.

Top module: `hdlc_rx_buffer`

## Requirements
- R1: The store holds up to DEPTH (default 128) entries in arrival order. `rx_level` gives the fill count. While the store is not empty, `rx_data`/`rx_last`/`rx_pkt_st` show the oldest entry, and `pop` removes that entry at the next edge. Packet codes: 0 good, 1 aborted, 2 bad CRC.
- R2: A byte offered while the store holds DEPTH entries and the receiver is not locked is not stored. It sets status bit 0 (overflow) and locks the receiver.
- R3: While the receiver is locked, offered bytes are dropped and do not set bit 0. A `flag_seen` pulse unlocks it from the next cycle, unless an overflowing write in that same cycle locks it again. A later byte that meets a still-full store overflows again.
- R4: Status bit 4 is set when an entry whose last-byte tag is 1 is stored.
- R5: Status bit 3 is set in any cycle where the head entry carries the last-byte tag. It is also set when `pop` is asserted on an empty store.
- R6: Status bit 1 is set in any cycle where `rx_level` is greater than `full_thresh`.
- R7: With `int_sel` low, status bit 2 is set by an `abort_seen` pulse only if at least 26 `bit_tick` pulses have come since the last flag or abort. A flag or an abort restarts this count. An earlier abort leaves bit 2 unchanged.
- R8: With `int_sel` high, status bit 2 is set by a `tx_underrun` pulse, and `abort_seen` has no effect on it.
- R9: Status bit 5 is set by a `goahead_seen` pulse.
- R10: A `stat_rd` pulse clears every status bit at the next edge, except a bit whose set condition holds in that same cycle. Bits 7 and 6 always read 0.
- R11: A `crc_valid` pulse loads `crc_word[15:8]` into `crc_msb` and `crc_word[7:0]` into `crc_lsb` with no bit changes. The values hold until the next pulse.
- R12: After reset the store is empty, the receiver is unlocked, the bit count is 0, and all status and CRC registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Deframer offers a byte this cycle |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte ends a packet |
| in_pkt_st | input | 2 | Packet outcome code for the offered byte |
| flag_seen | input | 1 | Deframer detected a flag |
| abort_seen | input | 1 | Deframer detected an abort sequence |
| goahead_seen | input | 1 | Deframer detected a go-ahead pattern |
| bit_tick | input | 1 | One received packet bit |
| crc_valid | input | 1 | CRC field of the packet just ended is on crc_word |
| crc_word | input | 16 | Received CRC field, as transmitted |
| tx_underrun | input | 1 | Transmitter read its empty store |
| int_sel | input | 1 | Selects the source of status bit 2 |
| full_thresh | input | 8 | Fill level above which bit 1 sets |
| pop | input | 1 | Host removes the head entry |
| stat_rd | input | 1 | Host reads (and clears) the status |
| rx_data | output | 8 | Head entry data |
| rx_last | output | 1 | Head entry last-byte tag |
| rx_pkt_st | output | 2 | Head entry packet outcome code |
| rx_level | output | 8 | Number of stored entries |
| stat_q | output | 8 | Sticky status bits |
| crc_msb | output | 8 | Upper byte of the captured CRC field |
| crc_lsb | output | 8 | Lower byte of the captured CRC field |

## Verification
The bench builds the block with its default parameters: a store of 128 entries and a 26-bit abort minimum. This makes the true capacity and the real abort rule reachable within a few hundred cycles. Directed runs fill the store exactly to capacity. They overflow it, stay locked through host pops, unlock on a flag and overflow again. They also try aborts at 25 and 26 counted bits. Random traffic with changing thresholds and select values then puts pops, reads and events into the same cycles.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        PKT_GOOD   = 2'd0,
        PKT_ABORT  = 2'd1,
        PKT_BADCRC = 2'd2
    } pkt_status_e;

    typedef struct packed {
        logic        last;
        pkt_status_e st;
        logic [7:0]  data;
    } rx_entry_t;

    localparam int NSTAT     = 6;
    localparam int ST_OVF    = 0;
    localparam int ST_FULL   = 1;
    localparam int ST_FA_UR  = 2;
    localparam int ST_EOPRD  = 3;
    localparam int ST_EOPWR  = 4;
    localparam int ST_GA     = 5;

    function automatic rx_entry_t make_entry(logic [7:0] d, logic l, logic [1:0] s);
        rx_entry_t e;
        e.data = d;
        e.last = l;
        e.st   = pkt_status_e'(s);
        return e;
    endfunction

endpackage

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  rx_entry_t       wr_entry,
    input  logic            rd_en,
    output rx_entry_t       head,
    output logic            empty,
    output logic            full,
    output logic [LW-1:0]   level
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [LW-1:0]   cnt;
    logic            do_wr, do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == DEPTH_L);
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;
    assign head  = mem[rp];
    assign level = cnt;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/hdlc_rx_wrgate.sv
module hdlc_rx_wrgate #(
    parameter int ABORT_MIN_BITS = 26,
    localparam int CW = $clog2(ABORT_MIN_BITS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic fifo_full,
    input  logic flag_seen,
    input  logic abort_seen,
    input  logic bit_tick,
    output logic wr_ok,
    output logic ovf_evt,
    output logic abort_ok,
    output logic locked
);
    localparam logic [CW-1:0] MIN_L = CW'(ABORT_MIN_BITS);

    logic          lock_q;
    logic [CW-1:0] bits_q;

    assign locked   = lock_q;
    assign wr_ok    = in_valid && !lock_q && !fifo_full;
    assign ovf_evt  = in_valid && !lock_q && fifo_full;
    assign abort_ok = abort_seen && (bits_q >= MIN_L);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (ovf_evt) begin
            lock_q <= 1'b1;
        end else if (flag_seen) begin
            lock_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (flag_seen || abort_seen) begin
            bits_q <= '0;
        end else if (bit_tick && bits_q < MIN_L) begin
            bits_q <= bits_q + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
    import hdlc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] set_vec,
    input  logic             rd,
    input  logic             crc_valid,
    input  logic [15:0]      crc_word,
    output logic [7:0]       stat_q,
    output logic [7:0]       crc_msb,
    output logic [7:0]       crc_lsb
);
    logic [NSTAT-1:0] sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= (rd ? '0 : sticky_q) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_msb <= '0;
            crc_lsb <= '0;
        end else if (crc_valid) begin
            crc_msb <= crc_word[15:8];
            crc_lsb <= crc_word[7:0];
        end
    end

    assign stat_q = {{(8 - NSTAT){1'b0}}, sticky_q};
endmodule

// File: rtl/hdlc_rx_buffer.sv
module hdlc_rx_buffer
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int ABORT_MIN_BITS = 26,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic [1:0]    in_pkt_st,
    input  logic          flag_seen,
    input  logic          abort_seen,
    input  logic          goahead_seen,
    input  logic          bit_tick,
    input  logic          crc_valid,
    input  logic [15:0]   crc_word,
    input  logic          tx_underrun,
    input  logic          int_sel,
    input  logic [LW-1:0] full_thresh,
    input  logic          pop,
    input  logic          stat_rd,
    output logic [7:0]    rx_data,
    output logic          rx_last,
    output logic [1:0]    rx_pkt_st,
    output logic [LW-1:0] rx_level,
    output logic [7:0]    stat_q,
    output logic [7:0]    crc_msb,
    output logic [7:0]    crc_lsb
);
    rx_entry_t        head;
    logic             empty, full;
    logic             wr_ok, ovf_evt, abort_ok, lock_q;
    logic [NSTAT-1:0] set_vec;

    hdlc_rx_wrgate #(.ABORT_MIN_BITS(ABORT_MIN_BITS)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .fifo_full (full),
        .flag_seen (flag_seen),
        .abort_seen(abort_seen),
        .bit_tick  (bit_tick),
        .wr_ok     (wr_ok),
        .ovf_evt   (ovf_evt),
        .abort_ok  (abort_ok),
        .locked    (lock_q)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_entry(make_entry(in_data, in_last, in_pkt_st)),
        .rd_en   (pop),
        .head    (head),
        .empty   (empty),
        .full    (full),
        .level   (rx_level)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[ST_OVF]   = ovf_evt;
        set_vec[ST_FULL]  = rx_level > full_thresh;
        set_vec[ST_FA_UR] = int_sel ? tx_underrun : abort_ok;
        set_vec[ST_EOPRD] = (!empty && head.last) || (pop && empty);
        set_vec[ST_EOPWR] = wr_ok && in_last;
        set_vec[ST_GA]    = goahead_seen;
    end

    hdlc_rx_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .rd       (stat_rd),
        .crc_valid(crc_valid),
        .crc_word (crc_word),
        .stat_q   (stat_q),
        .crc_msb  (crc_msb),
        .crc_lsb  (crc_lsb)
    );

    assign rx_data   = head.data;
    assign rx_last   = head.last;
    assign rx_pkt_st = head.st;
endmodule

// File: rtl/hdlc_rx_buffer_chk.sv
module hdlc_rx_buffer_chk #(
    parameter int DEPTH = 128,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          lock_q,
    input logic          pop,
    input logic          stat_rd,
    input logic          goahead_seen,
    input logic          tx_underrun,
    input logic          int_sel,
    input logic          crc_valid,
    input logic [15:0]   crc_word,
    input logic [LW-1:0] rx_level,
    input logic [7:0]    stat_q,
    input logic [7:0]    crc_msb,
    input logic [7:0]    crc_lsb
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_level <= DEPTH_L); // R1
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
        in_valid && !lock_q && rx_level == DEPTH_L |=> stat_q[0]); // R2
    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (rst)
        in_valid && lock_q |=> rx_level <= $past(rx_level)); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        pop && rx_level == '0 |=> stat_q[3]); // R5
    AST_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        int_sel && tx_underrun |=> stat_q[2]); // R8
    AST_GOAHEAD: assert property (@(posedge clk) disable iff (rst)
        goahead_seen |=> stat_q[5]); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !goahead_seen |=> !stat_q[5]); // R10
    AST_CRC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        crc_valid |=> {crc_msb, crc_lsb} == $past(crc_word)); // R11
endmodule

bind hdlc_rx_buffer hdlc_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .lock_q      (lock_q),
    .pop         (pop),
    .stat_rd     (stat_rd),
    .goahead_seen(goahead_seen),
    .tx_underrun (tx_underrun),
    .int_sel     (int_sel),
    .crc_valid   (crc_valid),
    .crc_word    (crc_word),
    .rx_level    (rx_level),
    .stat_q      (stat_q),
    .crc_msb     (crc_msb),
    .crc_lsb     (crc_lsb)
);

// File: tb/tb_hdlc_rx_buffer.sv
`timescale 1ns/1ps
module tb_hdlc_rx_buffer;
    localparam int DEPTH = 128;
    localparam int MINB  = 26;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, in_last = 0, flag_seen = 0, abort_seen = 0, goahead_seen = 0;
    logic bit_tick = 0, crc_valid = 0, tx_underrun = 0, int_sel = 0, pop = 0, stat_rd = 0;
    logic [7:0]    in_data = 0;
    logic [1:0]    in_pkt_st = 0;
    logic [15:0]   crc_word = 0;
    logic [LW-1:0] full_thresh = LW'(DEPTH);
    logic [7:0]    rx_data, stat_q, crc_msb, crc_lsb;
    logic          rx_last;
    logic [1:0]    rx_pkt_st;
    logic [LW-1:0] rx_level;

    int checks = 0, fails = 0;

    // reference state
    logic [10:0] mq[$];
    bit          mlock = 0;
    int          mcnt = 0;
    logic [7:0]  mstat = 0, mcm = 0, mcl = 0;

    always #4 clk = ~clk;

    hdlc_rx_buffer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_pkt_st(in_pkt_st), .flag_seen(flag_seen), .abort_seen(abort_seen),
        .goahead_seen(goahead_seen), .bit_tick(bit_tick), .crc_valid(crc_valid),
        .crc_word(crc_word), .tx_underrun(tx_underrun), .int_sel(int_sel),
        .full_thresh(full_thresh), .pop(pop), .stat_rd(stat_rd), .rx_data(rx_data),
        .rx_last(rx_last), .rx_pkt_st(rx_pkt_st), .rx_level(rx_level), .stat_q(stat_q),
        .crc_msb(crc_msb), .crc_lsb(crc_lsb)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string stat_tag(int b, bit sel);
        case (b)
            0: return "R2";
            1: return "R6";
            2: return sel ? "R8" : "R7";
            3: return "R5";
            4: return "R4";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare(bit sel_used);
        chk(rx_level == LW'(mq.size()), "R1 level", 32'(rx_level), 32'(mq.size()));
        if (mq.size() != 0)
            chk({rx_last, rx_pkt_st, rx_data} == mq[0], "R1 head",
                {rx_last, rx_pkt_st, rx_data}, mq[0]);
        for (int b = 0; b < 8; b++)
            chk(stat_q[b] == mstat[b], stat_tag(b, sel_used), 32'(stat_q[b]), 32'(mstat[b]));
        chk({crc_msb, crc_lsb} == {mcm, mcl}, "R11 crc", {crc_msb, crc_lsb}, {mcm, mcl});
    endtask

    // one clock: apply the driven inputs, advance the reference, compare at negedge
    task automatic tick();
        logic [7:0] s;
        bit full_now, ovf, wr, sel_used;
        full_now = (mq.size() == DEPTH);
        ovf = in_valid && !mlock && full_now;
        wr  = in_valid && !mlock && !full_now;
        sel_used = int_sel;
        s = '0;
        s[0] = ovf;
        s[1] = mq.size() > int'(full_thresh);
        s[2] = int_sel ? tx_underrun : (abort_seen && mcnt >= MINB);
        s[3] = (mq.size() != 0 && mq[0][10]) || (pop && mq.size() == 0);
        s[4] = wr && in_last;
        s[5] = goahead_seen;
        @(posedge clk);
        mstat = (stat_rd ? 8'h00 : mstat) | s;
        if (ovf) mlock = 1; else if (flag_seen) mlock = 0;
        if (flag_seen || abort_seen) mcnt = 0;
        else if (bit_tick && mcnt < MINB) mcnt++;
        if (pop && mq.size() != 0) void'(mq.pop_front());
        if (wr) mq.push_back({in_last, in_pkt_st, in_data});
        if (crc_valid) begin mcm = crc_word[15:8]; mcl = crc_word[7:0]; end
        @(negedge clk);
        compare(sel_used);
        {in_valid, pop, flag_seen, abort_seen, goahead_seen, bit_tick} = '0;
        {crc_valid, tx_underrun, stat_rd, in_last} = '0;
    endtask

    task automatic push(logic [7:0] d, logic l, logic [1:0] st);
        in_valid = 1; in_data = d; in_last = l; in_pkt_st = st; tick();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin bit_tick = 1; tick(); end
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R12: reset state
        chk(rx_level == 0, "R12 level", 32'(rx_level), 0);
        chk(stat_q == 0, "R12 status", 32'(stat_q), 0);
        chk({crc_msb, crc_lsb} == 0, "R12 crc", {crc_msb, crc_lsb}, 0);
        tick();

        // R11: capture as sent
        crc_valid = 1; crc_word = 16'hA35C; tick();
        tick();
        // R9 then R10: read clears
        goahead_seen = 1; tick();
        stat_rd = 1; tick();
        // R10: read with simultaneous set keeps the bit
        goahead_seen = 1; tick();
        stat_rd = 1; goahead_seen = 1; tick();
        stat_rd = 1; tick();

        // R1/R4/R6: fill exactly to capacity
        full_thresh = LW'(100);
        for (int i = 0; i < DEPTH; i++) push(8'(i), (i % 10) == 9, 2'(i % 3));
        stat_rd = 1; tick();
        // R2: overflow
        push(8'hEE, 1'b0, 2'd0);
        stat_rd = 1; tick();
        // R3: locked, pops do not reopen it
        pop = 1; tick();
        pop = 1; tick();
        push(8'hD1, 1'b1, 2'd1);
        push(8'hD2, 1'b0, 2'd0);
        // R3: flag unlocks
        flag_seen = 1; tick();
        push(8'hD3, 1'b0, 2'd2);
        push(8'hD4, 1'b1, 2'd0);
        stat_rd = 1; tick();
        // R3: overflow again on a still-full store
        push(8'hD5, 1'b0, 2'd0);
        // R5: drain then pop empty
        stat_rd = 1; tick();
        while (mq.size() != 0) begin pop = 1; tick(); end
        stat_rd = 1; tick();
        pop = 1; tick();
        stat_rd = 1; tick();

        // R7: abort after 25 bits ignored, after 26 counted
        flag_seen = 1; tick();
        ticks(25);
        abort_seen = 1; tick();
        ticks(26);
        abort_seen = 1; tick();
        stat_rd = 1; tick();
        // R8: select high
        int_sel = 1;
        ticks(30);
        abort_seen = 1; tick();
        tx_underrun = 1; tick();
        stat_rd = 1; tick();
        int_sel = 0;

        // constrained random traffic
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 200 == 0) int_sel = ~int_sel;
            if ($urandom % 100 == 0) full_thresh = LW'($urandom % (DEPTH + 1));
            in_valid     = ($urandom % 4) != 0;
            in_data      = 8'($urandom);
            in_last      = ($urandom % 8) == 0;
            in_pkt_st    = 2'($urandom % 3);
            pop          = ($urandom % 3) == 0;
            flag_seen    = ($urandom % 40) == 0;
            abort_seen   = ($urandom % 50) == 0;
            bit_tick     = ($urandom % 2) == 0;
            goahead_seen = ($urandom % 30) == 0;
            tx_underrun  = ($urandom % 30) == 0;
            stat_rd      = ($urandom % 6) == 0;
            crc_valid    = ($urandom % 20) == 0;
            crc_word     = 16'($urandom);
            tick();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule